// File: doc/BRIEF.md
# Byte Execute Unit: Arithmetic, Logic and Shift with Zero/Carry Flags

This block is the execute stage of a small byte-wide processor. Each clock it takes two operands, a function code, a group select, a 3-bit literal shift count and the current zero and carry flags. It registers an 8-bit result and the next values of both flags. The decode logic ahead of it supplies the second operand, which is either a register value or an immediate.

There are three operation groups, and each gives carry its own meaning. In the arithmetic group carry holds the carry out or the borrow out, and the with-carry forms also feed the incoming carry into the sum or difference. The logic group always clears carry. The shift group sets carry to the last bit that left the byte. A flag-write enable lets memory, I/O and control instructions pass both flags through unchanged while the result path still computes.

Top module: `exu8`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `res_q`, `z_q` and `c_q` are all cleared to 0.
- R2: Every output updates exactly one rising edge after its inputs are presented, and there is no combinational path from input to output.
- R3: With `is_shift`=0, `fn`=000 adds `opd_a`+`opd_b` and `fn`=001 adds `opd_a`+`opd_b`+`c_in`. When flags are written, `c_q` is the carry out of bit 7.
- R4: With `is_shift`=0, `fn`=010 computes `opd_a`-`opd_b` and `fn`=011 computes `opd_a`-`opd_b`-`c_in`. When flags are written, `c_q` is 1 exactly when the true difference is negative (borrow).
- R5: With `is_shift`=0, `fn`=100/101/110/111 compute bitwise AND, OR, XOR and mask (`opd_a` AND NOT `opd_b`). When flags are written, `c_q` is 0.
- R6: With `is_shift`=1, `fn[1:0]`=00/01/10/11 selects logical left shift, logical right shift, rotate left and rotate right of `opd_a` by `shamt`, and `fn[2]` has no effect. When flags are written, `c_q` is the last bit moved beyond the byte boundary: bit 8-`shamt` of `opd_a` for left moves and bit `shamt`-1 for right moves.
- R7: With `is_shift`=1 and `shamt`=0, `res_q` equals `opd_a` and `c_q` is 0 when flags are written.
- R8: When flags are written, `z_q` is 1 exactly when the registered 8-bit result is zero, for every operation.
- R9: With `flag_we`=0, `z_q` and `c_q` take the values of `z_in` and `c_in`, and `res_q` is still computed as in R3 to R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| is_shift | input | 1 | 1 selects the shift group, 0 the arithmetic/logic groups |
| fn | input | 3 | Function code within the selected group |
| opd_a | input | 8 | First operand, and the value that is shifted |
| opd_b | input | 8 | Second operand (register or immediate) |
| shamt | input | 3 | Literal shift/rotate count |
| c_in | input | 1 | Current carry flag |
| z_in | input | 1 | Current zero flag |
| flag_we | input | 1 | 1 writes new flags, 0 holds the incoming flags |
| res_q | output | 8 | Registered result |
| z_q | output | 1 | Registered next zero flag |
| c_q | output | 1 | Registered next carry flag |

## Verification
The hardest cases to reach are the carry edges of the with-carry forms. Examples are 0xFF plus 0 with an incoming carry, where the carry comes only from `c_in` and the result wraps to zero, and 0 minus 0 with a borrow in. Uniform random operands seldom land on these. Directed vectors drive them, together with shift counts of 0 and 7 on patterns whose edge bits differ. Random traffic then mixes every group with a random flag-write enable and random incoming flags, so that held flags and written flags follow each other back to back.

// File: rtl/exu8_pkg.sv
// Package: shared function encodings and the flag pair type for the byte
// execute unit. Assumes the group select picks which enum applies.
package exu8_pkg;

    // Arithmetic and logic function codes (group select low)
    typedef enum logic [2:0] {
        FN_ADD  = 3'b000,
        FN_ADDC = 3'b001,
        FN_SUB  = 3'b010,
        FN_SUBC = 3'b011,
        FN_AND  = 3'b100,
        FN_OR   = 3'b101,
        FN_XOR  = 3'b110,
        FN_MASK = 3'b111
    } alu_fn_e;

    // Shift function codes (group select high, low two bits of fn)
    typedef enum logic [1:0] {
        SH_LSL = 2'b00,
        SH_LSR = 2'b01,
        SH_ROL = 2'b10,
        SH_ROR = 2'b11
    } sh_fn_e;

    // Zero and carry flags carried together
    typedef struct packed {
        logic z;
        logic c;
    } flags_t;

endpackage

// File: rtl/exu8_addsub.sv
// Module: adder/subtractor for the arithmetic group.
// Computes a+b(+cin) or a-b(-cin). The extra top bit gives the carry out
// or the borrow out. Assumes fn_sub and use_c come straight from decode.
module exu8_addsub #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         fn_sub,
    input  logic         use_c,
    input  logic         cin,
    output logic [W-1:0] r,
    output logic         cout
);
    localparam int XW = W + 1;

    logic [XW-1:0] cin_ext;
    logic [XW-1:0] sum_x;
    logic [XW-1:0] dif_x;

    // Extend the incoming carry only for the with-carry forms
    always_comb begin
        cin_ext = {{W{1'b0}}, (use_c & cin)};
    end

    // Both paths at full width; the top bit is carry or borrow
    always_comb begin
        sum_x = {1'b0, a} + {1'b0, b} + cin_ext;
        dif_x = {1'b0, a} - {1'b0, b} - cin_ext;
        if (fn_sub) begin
            r    = dif_x[W-1:0];
            cout = dif_x[W];
        end else begin
            r    = sum_x[W-1:0];
            cout = sum_x[W];
        end
    end
endmodule

// File: rtl/exu8_logic.sv
// Module: bitwise unit for the logic group (AND, OR, XOR, AND-NOT).
// Built one bit slice at a time. Carry is not produced here; the top
// clears it for this group.
module exu8_logic #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [1:0]   sel,
    output logic [W-1:0] r
);
    // One slice per bit position
    for (genvar i = 0; i < W; i++) begin : g_slice
        always_comb begin
            unique case (sel)
                2'b00:   r[i] = a[i] & b[i];
                2'b01:   r[i] = a[i] | b[i];
                2'b10:   r[i] = a[i] ^ b[i];
                default: r[i] = a[i] & ~b[i];
            endcase
        end
    end
endmodule

// File: rtl/exu8_shift.sv
// Module: shifter/rotator for the shift group.
// Places the operand in a double-width field so that the bit leaving the
// byte lands next to the result edge and becomes carry. A count of zero
// leaves that slot empty, so carry is 0. Assumes cnt < W.
module exu8_shift #(
    parameter int W = 8,
    parameter int CW = $clog2(W)
) (
    input  logic [W-1:0]  a,
    input  logic [CW-1:0] cnt,
    input  logic [1:0]    sel,
    output logic [W-1:0]  r,
    output logic          cout
);
    localparam int DW = 2 * W;

    logic [DW-1:0] up_x;
    logic [DW-1:0] dn_x;

    // Left and right placements of the operand
    always_comb begin
        up_x = {{W{1'b0}}, a} << cnt;
        dn_x = {a, {W{1'b0}}} >> cnt;
    end

    // Select the variant; rotates fold the spilled half back in
    always_comb begin
        unique case (sel)
            2'b00: begin
                r    = up_x[W-1:0];
                cout = up_x[W];
            end
            2'b01: begin
                r    = dn_x[DW-1:W];
                cout = dn_x[W-1];
            end
            2'b10: begin
                r    = up_x[W-1:0] | up_x[DW-1:W];
                cout = up_x[W];
            end
            default: begin
                r    = dn_x[DW-1:W] | dn_x[W-1:0];
                cout = dn_x[W-1];
            end
        endcase
    end
endmodule

// File: rtl/exu8.sv
// Module: byte execute unit, top level.
// Picks the arithmetic, logic or shift result and registers the result and
// the next zero/carry flags one cycle after the inputs. With the flag-write
// enable low it registers the incoming flags unchanged. Assumes operand
// selection (register or immediate) happens upstream.
module exu8 #(
    parameter int W = 8,
    parameter int CW = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          is_shift,
    input  logic [2:0]    fn,
    input  logic [W-1:0]  opd_a,
    input  logic [W-1:0]  opd_b,
    input  logic [CW-1:0] shamt,
    input  logic          c_in,
    input  logic          z_in,
    input  logic          flag_we,
    output logic [W-1:0]  res_q,
    output logic          z_q,
    output logic          c_q
);
    import exu8_pkg::*;

    logic [W-1:0] as_r;
    logic         as_c;
    logic [W-1:0] lg_r;
    logic [W-1:0] sh_r;
    logic         sh_c;
    logic [W-1:0] res_d;
    flags_t       flg_d;
    logic         c_new;

    exu8_addsub #(.W(W)) u_addsub (
        .a      (opd_a),
        .b      (opd_b),
        .fn_sub (fn[1]),
        .use_c  (fn[0]),
        .cin    (c_in),
        .r      (as_r),
        .cout   (as_c)
    );

    exu8_logic #(.W(W)) u_logic (
        .a   (opd_a),
        .b   (opd_b),
        .sel (fn[1:0]),
        .r   (lg_r)
    );

    exu8_shift #(.W(W), .CW(CW)) u_shift (
        .a    (opd_a),
        .cnt  (shamt),
        .sel  (fn[1:0]),
        .r    (sh_r),
        .cout (sh_c)
    );

    // Group result and group-specific carry meaning
    always_comb begin
        if (is_shift) begin
            res_d = sh_r;
            c_new = sh_c;
        end else if (fn[2]) begin
            res_d = lg_r;
            c_new = 1'b0;
        end else begin
            res_d = as_r;
            c_new = as_c;
        end
    end

    // Next flags: written or passed through
    always_comb begin
        if (flag_we) begin
            flg_d.z = (res_d == '0);
            flg_d.c = c_new;
        end else begin
            flg_d.z = z_in;
            flg_d.c = c_in;
        end
    end

    // Output register with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
            z_q   <= 1'b0;
            c_q   <= 1'b0;
        end else begin
            res_q <= res_d;
            z_q   <= flg_d.z;
            c_q   <= flg_d.c;
        end
    end
endmodule

// File: rtl/exu8_chk.sv
// Module: property checker for the byte execute unit, bound to every
// instance. Observes ports only.
module exu8_chk #(
    parameter int W = 8,
    parameter int CW = $clog2(W)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          is_shift,
    input logic          fn_hi,
    input logic [W-1:0]  opd_a,
    input logic [CW-1:0] shamt,
    input logic          c_in,
    input logic          z_in,
    input logic          flag_we,
    input logic [W-1:0]  res_q,
    input logic          z_q,
    input logic          c_q
);
    // R1
    rst_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (res_q == '0) && !z_q && !c_q);

    // R9
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !flag_we) |=> (z_q == $past(z_in)) && (c_q == $past(c_in)));

    // R5
    logic_c_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && flag_we && !is_shift && fn_hi) |=> !c_q);

    // R7
    shift_zero_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && is_shift && shamt == '0) |=>
            (res_q == $past(opd_a)) && ($past(flag_we) ? !c_q : 1'b1));

    // R8
    zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && flag_we) |=> (z_q == (res_q == '0)));
endmodule

bind exu8 exu8_chk #(.W(W), .CW(CW)) u_exu8_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .is_shift (is_shift),
    .fn_hi    (fn[2]),
    .opd_a    (opd_a),
    .shamt    (shamt),
    .c_in     (c_in),
    .z_in     (z_in),
    .flag_we  (flag_we),
    .res_q    (res_q),
    .z_q      (z_q),
    .c_q      (c_q)
);

// File: tb/test_exu8.sv
module test_exu8;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       is_shift = 1'b0;
    logic [2:0] fn = '0;
    logic [7:0] opd_a = '0;
    logic [7:0] opd_b = '0;
    logic [2:0] shamt = '0;
    logic       c_in = 1'b0;
    logic       z_in = 1'b0;
    logic       flag_we = 1'b0;
    logic [7:0] res_q;
    logic       z_q;
    logic       c_q;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    exu8 i_exu8 (
        .clk(clk), .rst_n(rst_n), .is_shift(is_shift), .fn(fn),
        .opd_a(opd_a), .opd_b(opd_b), .shamt(shamt), .c_in(c_in),
        .z_in(z_in), .flag_we(flag_we), .res_q(res_q), .z_q(z_q), .c_q(c_q)
    );

    // Reference model: returns {z, c, result}
    function automatic logic [9:0] ref_model(input logic sh, input logic [2:0] f,
            input logic [7:0] a, input logic [7:0] b, input logic [2:0] n,
            input logic ci, input logic zi, input logic we);
        int ia, ib, ic, t;
        logic [7:0] r;
        logic c;
        ia = int'(a); ib = int'(b); ic = int'(ci);
        c = 1'b0;
        if (sh) begin
            case (f[1:0])
                2'b00: begin r = 8'((ia << n) & 255); c = (n != 0) ? a[8 - int'(n)] : 1'b0; end
                2'b01: begin r = 8'(ia >> n);         c = (n != 0) ? a[int'(n) - 1] : 1'b0; end
                2'b10: begin r = 8'(((ia << n) | (ia >> (8 - int'(n)))) & 255);
                             c = (n != 0) ? a[8 - int'(n)] : 1'b0; end
                default: begin r = 8'(((ia >> n) | (ia << (8 - int'(n)))) & 255);
                             c = (n != 0) ? a[int'(n) - 1] : 1'b0; end
            endcase
        end else begin
            case (f)
                3'b000: begin t = ia + ib;      r = 8'(t & 255); c = (t > 255); end
                3'b001: begin t = ia + ib + ic; r = 8'(t & 255); c = (t > 255); end
                3'b010: begin t = ia - ib;      r = 8'(t & 255); c = (t < 0);   end
                3'b011: begin t = ia - ib - ic; r = 8'(t & 255); c = (t < 0);   end
                3'b100: r = a & b;
                3'b101: r = a | b;
                3'b110: r = a ^ b;
                default: r = a & ~b;
            endcase
        end
        if (we) return {(r == 8'h00), c, r};
        return {zi, ci, r};
    endfunction

    function automatic string req_of(input logic sh, input logic [2:0] f,
            input logic [2:0] n, input logic we);
        if (!we) return "R9";
        if (sh && n == 0) return "R7";
        if (sh) return "R6";
        if (f[2]) return "R5";
        if (f[1]) return "R4";
        return "R3";
    endfunction

    // Drive one vector at the falling edge, check one edge later (R2, R8)
    task automatic apply(input logic sh, input logic [2:0] f, input logic [7:0] a,
            input logic [7:0] b, input logic [2:0] n, input logic ci,
            input logic zi, input logic we);
        logic [9:0] exp;
        @(negedge clk);
        is_shift = sh; fn = f; opd_a = a; opd_b = b; shamt = n;
        c_in = ci; z_in = zi; flag_we = we;
        exp = ref_model(sh, f, a, b, n, ci, zi, we);
        @(posedge clk);
        #1;
        n_run++;
        if ({z_q, c_q, res_q} !== exp) begin
            n_fail++;
            $display("FAIL %s/R8/R2 sh=%0b fn=%03b a=%02h b=%02h n=%0d ci=%0b zi=%0b we=%0b: got z=%0b c=%0b r=%02h exp z=%0b c=%0b r=%02h",
                req_of(sh, f, n, we), sh, f, a, b, n, ci, zi, we,
                z_q, c_q, res_q, exp[9], exp[8], exp[7:0]);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired: got running expected finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        // R1: reset clears everything, even with inputs that would set flags
        @(negedge clk);
        opd_a = 8'hFF; opd_b = 8'h01; flag_we = 1'b1; c_in = 1'b1; z_in = 1'b1;
        @(posedge clk); #1;
        n_run++;
        if (res_q !== 8'h00 || z_q !== 1'b0 || c_q !== 1'b0) begin
            n_fail++;
            $display("FAIL R1 got r=%02h z=%0b c=%0b expected r=00 z=0 c=0", res_q, z_q, c_q);
        end
        @(negedge clk);
        rst_n = 1'b1;

        // R3 corners: carry out, carry only from c_in wrapping to zero
        apply(0, 3'b000, 8'hFF, 8'h01, 0, 0, 0, 1);
        apply(0, 3'b001, 8'hFF, 8'h00, 0, 1, 0, 1);
        apply(0, 3'b000, 8'h05, 8'h18, 0, 1, 1, 1);
        apply(0, 3'b001, 8'h80, 8'h7F, 0, 0, 0, 1);
        // R4 corners: borrow, borrow from c_in only, equal operands
        apply(0, 3'b010, 8'h00, 8'h01, 0, 0, 0, 1);
        apply(0, 3'b011, 8'h00, 8'h00, 0, 1, 0, 1);
        apply(0, 3'b010, 8'h3C, 8'h3C, 0, 1, 0, 1);
        apply(0, 3'b011, 8'h10, 8'h0F, 0, 1, 0, 1);
        // R5: logic ops clear carry even with c_in high
        apply(0, 3'b100, 8'hF0, 8'h0F, 0, 1, 0, 1);
        apply(0, 3'b101, 8'hA0, 8'h05, 0, 1, 0, 1);
        apply(0, 3'b110, 8'hFF, 8'hFF, 0, 1, 0, 1);
        apply(0, 3'b111, 8'hF3, 8'h31, 0, 1, 0, 1);
        // R6: edge counts and patterns with differing edge bits; fn[2] ignored
        apply(1, 3'b000, 8'h81, 8'h00, 7, 0, 0, 1);
        apply(1, 3'b001, 8'h81, 8'h00, 7, 0, 0, 1);
        apply(1, 3'b110, 8'h96, 8'h00, 1, 0, 0, 1);
        apply(1, 3'b111, 8'h69, 8'h00, 3, 0, 0, 1);
        apply(1, 3'b100, 8'h02, 8'h00, 1, 0, 0, 1);
        // R7: zero count passes through and clears carry
        apply(1, 3'b000, 8'hA5, 8'h00, 0, 1, 0, 1);
        apply(1, 3'b011, 8'h00, 8'h00, 0, 1, 0, 1);
        // R9: flags held while result still computes
        apply(0, 3'b000, 8'hFF, 8'h01, 0, 0, 1, 0);
        apply(1, 3'b010, 8'h01, 8'h00, 1, 1, 0, 0);
        apply(0, 3'b100, 8'h00, 8'h00, 0, 1, 0, 0);

        // Random mix across all groups
        for (int k = 0; k < 2000; k++) begin
            apply(1'($urandom), 3'($urandom), 8'($urandom), 8'($urandom),
                  3'($urandom), 1'($urandom), 1'($urandom),
                  ($urandom % 4) != 0);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule